// File: doc/BRIEF.md
# DCO Tap Modulator Controller

This block is the digital control for a digitally controlled oscillator whose analog core is not part of it. Every cycle of the oscillator clock it gives the core a range code and a step code. The step code is either the programmed base step or the step directly above it. Over a fixed frame of 32 oscillator cycles, the step above is used for exactly as many cycles as the programmed modulation count. The average output frequency therefore lands between the two adjacent steps, in 1/32 increments.

The controller takes an 8-bit configuration word that packs the step and the modulation count. It also takes a 4-bit range select and a flag for the external-resistor mode. All of these are captured only on the last cycle of each frame, so a frame never mixes two settings. The higher-step cycles are spread through the frame by a modulo-32 phase accumulator rather than grouped into one burst. At the top step, modulation is suppressed. In external-resistor mode, the top range bit is forced low.

Top module: `dco_tap_modulator`

## Requirements
- R1: After reset the active setting is step 3, modulation count 0, range 7 and internal-resistor mode, and the frame counter is 0. The first 32 cycles therefore output step 3 and range 7 on every cycle.
- R2: In `cfgWord`, bits 7:5 hold the base step and bits 4:0 hold the modulation count. The reset setting is equivalent to the word 0x60.
- R3: For a base step from 0 to 6, each frame of 32 cycles outputs base+1 on exactly MOD cycles and the base step on the remaining 32−MOD cycles.
- R4: When the base step is 7, the output is 7 on every cycle of the frame, whatever the modulation count.
- R5: `tapStep` is always either the active base step or base+1.
- R6: Within a frame, when MOD ≤ 16 no two adjacent cycles both output base+1. When MOD ≥ 16 (and the step is below 7), no two adjacent cycles both output the base step.
- R7: `tapRange` equals the captured range when the resistor flag is 0. When the flag is 1, bit 3 of `tapRange` is 0 and bits 2:0 are the captured range's bits 2:0.
- R8: Inputs are captured only on the last cycle of a frame (cycle 31) and take effect from the next frame. Changes at other cycles do not affect the running frame, and the value present at cycle 31 wins.
- R9: A frame is exactly 32 oscillator cycles. The frame counter wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 8 | Step in bits 7:5, modulation count in bits 4:0 |
| rangeSel | input | 4 | Frequency range select, 0 lowest |
| extResMode | input | 1 | External-resistor mode; masks the top range bit |
| tapRange | output | 4 | Effective range for the current cycle |
| tapStep | output | 3 | Effective step for the current cycle |

## Verification
Several properties are checked by assertions on every cycle:
- the frame counter's wrap and increment;
- the phase accumulator being back at zero at every frame start;
- the step output staying within one step of the base, and being pinned at the top step;
- the masked range bit;
- the adjacency spreading rule;
- the captured setting holding steady between frame ends.

Other behaviour can only be shown by the bench's scenarios:
- the exact count of higher-step cycles per frame for each of the 256 step and modulation pairs;
- the reset setting;
- the fact that a mid-frame change or a last-cycle change lands on the following frame and not the current one.

// File: rtl/dcomod_pkg.sv
package dcomod_pkg;
  // Strobes from the frame sequencer to the modulation datapath
  typedef struct packed {
    logic frameFirst;  // first cycle of a frame
    logic frameLast;   // last cycle of a frame: setting capture point
  } frameStrobe_t;
endpackage

// File: rtl/dcomod_frame_ctrl.sv
module dcomod_frame_ctrl
  import dcomod_pkg::*;
#(
  parameter int MOD_W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  output frameStrobe_t strobe
);
  logic [MOD_W-1:0] frameCnt;

  // Free-running frame position, natural wrap at 2**MOD_W
  always_ff @(posedge clk) begin
    if (!rstN) frameCnt <= '0;
    else       frameCnt <= frameCnt + MOD_W'(1);
  end

  always_comb begin
    strobe.frameFirst = (frameCnt == '0);
    strobe.frameLast  = (frameCnt == '1);
  end

  assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameCnt == '1) |=> (frameCnt == '0));
  assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameCnt != '1) |=> (frameCnt == $past(frameCnt) + MOD_W'(1)));
endmodule

// File: rtl/dcomod_tap_datapath.sv
module dcomod_tap_datapath
  import dcomod_pkg::*;
#(
  parameter int STEP_W    = 3,
  parameter int MOD_W     = 5,
  parameter int RANGE_W   = 4,
  parameter int STEP_RST  = 3,
  parameter int MOD_RST   = 0,
  parameter int RANGE_RST = 7,
  localparam int CFG_W    = STEP_W + MOD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  frameStrobe_t       strobe,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic [RANGE_W-1:0] rangeSel,
  input  logic               extResMode,
  output logic [RANGE_W-1:0] tapRange,
  output logic [STEP_W-1:0]  tapStep
);
  localparam logic [STEP_W-1:0] TOP_STEP = {STEP_W{1'b1}};
  localparam logic [MOD_W-1:0]  HALF     = MOD_W'(1 << (MOD_W - 1));

  logic [STEP_W-1:0]  stepQ;
  logic [MOD_W-1:0]   modQ;
  logic [RANGE_W-1:0] rangeQ;
  logic               resQ;
  logic [MOD_W-1:0]   accQ;
  logic [MOD_W:0]     phaseSum;
  logic               useHigher;

  // Setting shadow: captured only at the frame end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ  <= STEP_W'(STEP_RST);
      modQ   <= MOD_W'(MOD_RST);
      rangeQ <= RANGE_W'(RANGE_RST);
      resQ   <= 1'b0;
    end else if (strobe.frameLast) begin
      stepQ  <= cfgWord[CFG_W-1:MOD_W];
      modQ   <= cfgWord[MOD_W-1:0];
      rangeQ <= rangeSel;
      resQ   <= extResMode;
    end
  end

  // Phase accumulator: adding MOD per cycle over 2**MOD_W cycles yields
  // exactly MOD carries and returns to zero at the frame end
  assign phaseSum = {1'b0, accQ} + {1'b0, modQ};

  always_ff @(posedge clk) begin
    if (!rstN) accQ <= '0;
    else       accQ <= phaseSum[MOD_W-1:0];
  end

  assign useHigher = phaseSum[MOD_W] && (stepQ != TOP_STEP);
  assign tapStep   = stepQ + STEP_W'(useHigher);

  generate
    if (RANGE_W > 1) begin : g_rangeMask
      assign tapRange = resQ ? {1'b0, rangeQ[RANGE_W-2:0]} : rangeQ;
    end else begin : g_rangeOne
      assign tapRange = resQ ? '0 : rangeQ;
    end
  endgenerate

  assert_acc_frame_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameFirst |-> (accQ == '0));
  assert_top_step_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == TOP_STEP) |-> (tapStep == TOP_STEP));
  assert_step_adjacent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tapStep == stepQ) || (tapStep == stepQ + STEP_W'(1)));
  assert_spread_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (useHigher && (modQ <= HALF) && !strobe.frameLast) |=> !useHigher);
  assert_spread_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!useHigher && (stepQ != TOP_STEP) && (modQ >= HALF) && !strobe.frameLast)
      |=> useHigher);
  assert_range_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    resQ |-> !tapRange[RANGE_W-1]);
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameLast |=> ($stable(stepQ) && $stable(modQ) &&
                           $stable(rangeQ) && $stable(resQ)));
endmodule

// File: rtl/dco_tap_modulator.sv
module dco_tap_modulator
  import dcomod_pkg::*;
#(
  parameter int STEP_W    = 3,
  parameter int MOD_W     = 5,
  parameter int RANGE_W   = 4,
  parameter int STEP_RST  = 3,
  parameter int MOD_RST   = 0,
  parameter int RANGE_RST = 7,
  localparam int CFG_W    = STEP_W + MOD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic [RANGE_W-1:0] rangeSel,
  input  logic               extResMode,
  output logic [RANGE_W-1:0] tapRange,
  output logic [STEP_W-1:0]  tapStep
);
  frameStrobe_t strobe;

  dcomod_frame_ctrl #(.MOD_W(MOD_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  dcomod_tap_datapath #(
    .STEP_W(STEP_W), .MOD_W(MOD_W), .RANGE_W(RANGE_W),
    .STEP_RST(STEP_RST), .MOD_RST(MOD_RST), .RANGE_RST(RANGE_RST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWord    (cfgWord),
    .rangeSel   (rangeSel),
    .extResMode (extResMode),
    .tapRange   (tapRange),
    .tapStep    (tapStep)
  );
endmodule

// File: tb/dco_tap_modulator_tb.sv
`timescale 1ns/100ps
module dco_tap_modulator_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgWord = 8'h00;
  logic [3:0] rangeSel = 4'd0;
  logic       extResMode = 1'b0;
  logic [3:0] tapRange;
  logic [2:0] tapStep;

  always #2.5 clk = ~clk;  // 200 MHz

  dco_tap_modulator u_dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .rangeSel(rangeSel),
    .extResMode(extResMode), .tapRange(tapRange), .tapStep(tapStep)
  );

  typedef struct {
    int    step;
    int    mod;
    int    rng;
    string tag;
  } frameExp_t;

  frameExp_t expQ[$];
  int  nTests = 0;
  int  nFail = 0;
  int  dcyc = 0;
  bit  started = 0;
  bit  monDone = 0;
  localparam int TOTAL_FRAMES = 259;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    dcyc++;
  endtask

  task automatic waitTo(int target);
    while (dcyc < target) tick();
  endtask

  task automatic driveCfg(int s, int m, int r, bit res);
    cfgWord    = {s[2:0], m[4:0]};  // R2: step in 7:5, mod in 4:0
    rangeSel   = r[3:0];
    extResMode = res;
  endtask

  // Driver side of the scoreboard: expected setting for a future frame
  task automatic pushExp(int s, int m, int r, bit res, string tag);
    frameExp_t e;
    e.step = s;
    e.mod  = m;
    e.rng  = res ? (r & 7) : r;  // R7
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // Monitor: pops one expected item per 32-cycle frame (R9)
  initial begin
    wait (started);
    for (int f = 0; f < TOTAL_FRAMES; f++) begin
      frameExp_t e;
      int hi;
      bit prevHi;
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "scoreboard empty at frame", f, 1);
        e.step = 0; e.mod = 0; e.rng = 0; e.tag = "R9";
      end else begin
        e = expQ.pop_front();
      end
      hi = 0;
      prevHi = 0;
      for (int k = 0; k < 32; k++) begin
        bit isHi;
        #1;
        isHi = (e.step < 7) && (int'(tapStep) == e.step + 1);
        check(int'(tapStep) == e.step || isHi, {e.tag, " R5 R4"},
              "step out of band", int'(tapStep), e.step);
        check(int'(tapRange) == e.rng, {e.tag, " R7"}, "range", int'(tapRange), e.rng);
        if (k > 0) begin
          check(!(e.mod <= 16 && isHi && prevHi), {e.tag, " R6"},
                "adjacent higher cycles at mod", e.mod, 16);
          check(!(e.mod >= 16 && e.step < 7 && !isHi && !prevHi), {e.tag, " R6"},
                "adjacent base cycles at mod", e.mod, 16);
        end
        prevHi = isHi;
        hi += int'(isHi);
        @(negedge clk);
      end
      check(hi == ((e.step == 7) ? 0 : e.mod), {e.tag, " R3 R4 R9"},
            "higher-step cycles in frame", hi, (e.step == 7) ? 0 : e.mod);
    end
    monDone = 1;
  end

  initial begin
    // R1: frame 0 runs on the reset setting (0x60 word, range 7) -- R2
    pushExp(3, 0, 7, 1'b0, "R1 R2");
    driveCfg(7, 31, 15, 1'b1);  // ignored while in reset
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    dcyc = 0;
    started = 1;
    // R2 R3 R4: every step/mod pair, range and resistor flag varied
    for (int f = 1; f <= 256; f++) begin
      int s, m, r;
      bit res;
      s = (f - 1) / 32;
      m = (f - 1) % 32;
      r = (s * 5 + m) % 16;
      res = m[0];
      waitTo(32 * (f - 1) + 4);
      driveCfg(s, m, r, res);
      pushExp(s, m, r, res, (s == 7) ? "R4" : "R3");
    end
    // R8: decoy early in frame 256, real value on its last cycle
    waitTo(32 * 256 + 4);
    driveCfg(0, 31, 15, 1'b0);
    waitTo(32 * 256 + 31);
    driveCfg(5, 16, 12, 1'b1);
    pushExp(5, 16, 12, 1'b1, "R8");
    // R8: mid-frame change in frame 257 only affects frame 258
    waitTo(32 * 257 + 20);
    driveCfg(2, 9, 9, 1'b0);
    pushExp(2, 9, 9, 1'b0, "R8");
    wait (monDone);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!monDone) begin
      nTests++;
      nFail++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule